// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control-unit state machine of a small stored-program machine. It owns the program counter and the instruction register. It steps every instruction through six phases in a fixed order: instruction fetch, decode, address evaluation, operand fetch, execute and result write-back. In each phase it raises exactly one enable toward the memory port, the address adder, the ALU or the register file.

The instruction encoding lives outside the block. During the decode phase a neighbouring decoder looks at the instruction register and returns three hints. The first says whether the instruction has a memory operand. The second says whether the result goes to memory or to a register. The third gives the index of the destination register among the general-purpose registers. Instructions without a memory operand go straight from decode to execute. Memory accesses finish when the memory answers with a one-cycle done pulse.

Top module: `icseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer goes to the fetch phase and clears the program counter. This holds at any time, including in the middle of an instruction.
- R2: In the fetch phase (code 0), `mem_rd_en` is high. The phase stays at fetch for every cycle in which `mem_done` is low.
- R3: At a fetch edge with `mem_done` high, `ir` takes `mem_rdata` and the program counter advances by one, wrapping modulo 2^ADDR_W. It does not change at any other time except reset.
- R4: The phase codes are fetch=0, decode=1, address=2, operand=3, execute=4, store=5. A completed fetch always leads to decode, which lasts one cycle with `decode_en` high.
- R5: If `hint_mem_op` is high in decode, the next phases are address (code 2, one cycle, `addr_en` high) and then operand. If it is low, decode is followed directly by execute.
- R6: In the operand phase, `mem_rd_en` is high. The phase waits there until `mem_done` is seen, then moves to execute.
- R7: Execute lasts one cycle with `alu_en` high and is always followed by store.
- R8: A store to memory (`hint_mem_dst` high in decode) holds `mem_wr_en` high in the store phase until `mem_done`, then returns to fetch.
- R9: A store to a register lasts one cycle. `reg_wr_en` is high and `reg_wr_sel` is one-hot at bit `hint_dst` (as captured in decode). The next phase is fetch. `reg_wr_sel` is zero whenever `reg_wr_en` is low.
- R10: The hints are sampled only in the decode phase. Changing them in any other phase has no effect on the phases that follow or on the register select.
- R11: In every cycle out of reset, exactly one of `mem_rd_en`, `mem_wr_en`, `decode_en`, `addr_en`, `alu_en` and `reg_wr_en` is high.
- R12: A `mem_done` pulse in decode, address, execute or register-store phases is ignored. It does not change the phase order or the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_done | input | 1 | Memory access complete |
| mem_rdata | input | WORD_W | Word returned by memory during fetch |
| hint_mem_op | input | 1 | Decoder: instruction has a memory operand |
| hint_mem_dst | input | 1 | Decoder: result goes to memory |
| hint_dst | input | $clog2(NUM_GPR) | Decoder: destination register index |
| phase | output | 3 | Current phase code |
| pc | output | ADDR_W | Address of the next instruction |
| ir | output | WORD_W | Instruction being executed |
| mem_rd_en | output | 1 | Memory read (fetch or operand) |
| mem_wr_en | output | 1 | Memory write of the result |
| decode_en | output | 1 | Decoder strobe |
| addr_en | output | 1 | Effective-address computation |
| alu_en | output | 1 | ALU operation |
| reg_wr_en | output | 1 | Register write of the result |
| reg_wr_sel | output | NUM_GPR | One-hot destination register select |

## Verification
The hardest case to reach is a hint that changes after decode. The captured value and the live input then disagree while the store phase uses the captured one. The stimulus drives the inverse of the intended hints in every phase except decode. Each register-store check therefore only matches if the sampled copy was used. Stray `mem_done` pulses are placed in the single-cycle phases. The program counter is made four bits wide, so a run of sixteen instructions shows the wrap.

// File: rtl/icseq_pkg.sv
package icseq_pkg;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_ADDR   = 3'd2,
        PH_OPND   = 3'd3,
        PH_EXEC   = 3'd4,
        PH_STORE  = 3'd5
    } phase_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic dec;
        logic addr;
        logic alu;
        logic reg_wr;
    } ctl_t;

    function automatic phase_t next_phase(input phase_t cur, input logic done,
                                          input logic mem_op, input logic to_mem);
        phase_t nx;
        nx = cur;
        case (cur)
            PH_FETCH:  if (done) nx = PH_DECODE;
            PH_DECODE: nx = mem_op ? PH_ADDR : PH_EXEC;
            PH_ADDR:   nx = PH_OPND;
            PH_OPND:   if (done) nx = PH_EXEC;
            PH_EXEC:   nx = PH_STORE;
            PH_STORE:  if (!to_mem || done) nx = PH_FETCH;
            default:   nx = PH_FETCH;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/icseq_phase_fsm.sv
module icseq_phase_fsm
    import icseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mem_done,
    input  logic   hint_mem_op,
    input  logic   to_mem_q,
    output phase_t phase_q
);
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_FETCH;
        else     phase_q <= next_phase(phase_q, mem_done, hint_mem_op, to_mem_q);
    end
endmodule

// File: rtl/icseq_state_regs.sv
module icseq_state_regs
    import icseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase_q,
    input  logic              mem_done,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              hint_mem_dst,
    input  logic [IDX_W-1:0]  hint_dst,
    output logic [ADDR_W-1:0] pc_q,
    output logic [WORD_W-1:0] ir_q,
    output logic              to_mem_q,
    output logic [IDX_W-1:0]  dst_q
);
    logic fetch_done;
    assign fetch_done = (phase_q == PH_FETCH) && mem_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            to_mem_q <= 1'b0;
            dst_q    <= '0;
        end else begin
            if (fetch_done) begin
                ir_q <= mem_rdata;
                pc_q <= pc_q + 1'b1;
            end
            if (phase_q == PH_DECODE) begin
                to_mem_q <= hint_mem_dst;
                dst_q    <= hint_dst;
            end
        end
    end
endmodule

// File: rtl/icseq_ctl_decode.sv
module icseq_ctl_decode
    import icseq_pkg::*;
#(
    parameter int NUM_GPR = 8,
    parameter int IDX_W   = 3
) (
    input  phase_t             phase_q,
    input  logic               to_mem_q,
    input  logic [IDX_W-1:0]   dst_q,
    output ctl_t               ctl,
    output logic [NUM_GPR-1:0] sel
);
    always_comb begin
        ctl = '0;
        case (phase_q)
            PH_FETCH, PH_OPND: ctl.mem_rd = 1'b1;
            PH_DECODE:         ctl.dec    = 1'b1;
            PH_ADDR:           ctl.addr   = 1'b1;
            PH_EXEC:           ctl.alu    = 1'b1;
            PH_STORE: begin
                ctl.mem_wr = to_mem_q;
                ctl.reg_wr = !to_mem_q;
            end
            default:           ctl = '0;
        endcase
    end

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_sel
        assign sel[g] = ctl.reg_wr && (dst_q == IDX_W'(g));
    end
endmodule

// File: rtl/icseq_top.sv
module icseq_top
    import icseq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int WORD_W  = 16,
    parameter int NUM_GPR = 8,
    localparam int IDX_W  = $clog2(NUM_GPR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_done,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               hint_mem_op,
    input  logic               hint_mem_dst,
    input  logic [IDX_W-1:0]   hint_dst,
    output logic [2:0]         phase,
    output logic [ADDR_W-1:0]  pc,
    output logic [WORD_W-1:0]  ir,
    output logic               mem_rd_en,
    output logic               mem_wr_en,
    output logic               decode_en,
    output logic               addr_en,
    output logic               alu_en,
    output logic               reg_wr_en,
    output logic [NUM_GPR-1:0] reg_wr_sel
);
    phase_t            phase_q;
    logic              to_mem_q;
    logic [IDX_W-1:0]  dst_q;
    ctl_t              ctl;

    icseq_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .mem_done(mem_done),
        .hint_mem_op(hint_mem_op), .to_mem_q(to_mem_q), .phase_q(phase_q)
    );

    icseq_state_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .phase_q(phase_q), .mem_done(mem_done),
        .mem_rdata(mem_rdata), .hint_mem_dst(hint_mem_dst), .hint_dst(hint_dst),
        .pc_q(pc), .ir_q(ir), .to_mem_q(to_mem_q), .dst_q(dst_q)
    );

    icseq_ctl_decode #(.NUM_GPR(NUM_GPR), .IDX_W(IDX_W)) u_ctl (
        .phase_q(phase_q), .to_mem_q(to_mem_q), .dst_q(dst_q),
        .ctl(ctl), .sel(reg_wr_sel)
    );

    assign phase     = phase_q;
    assign mem_rd_en = ctl.mem_rd;
    assign mem_wr_en = ctl.mem_wr;
    assign decode_en = ctl.dec;
    assign addr_en   = ctl.addr;
    assign alu_en    = ctl.alu;
    assign reg_wr_en = ctl.reg_wr;
endmodule

// File: rtl/icseq_checker.sv
module icseq_checker #(
    parameter int ADDR_W  = 16,
    parameter int NUM_GPR = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               mem_done,
    input logic               hint_mem_op,
    input logic [2:0]         phase,
    input logic [ADDR_W-1:0]  pc,
    input logic               mem_rd_en,
    input logic               mem_wr_en,
    input logic               decode_en,
    input logic               addr_en,
    input logic               alu_en,
    input logic               reg_wr_en,
    input logic [NUM_GPR-1:0] reg_wr_sel
);
    a_r11_one_enable: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_rd_en, mem_wr_en, decode_en, addr_en, alu_en, reg_wr_en}) == 1);

    a_r2_fetch_wait: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 && !mem_done) |=> (phase == 3'd0));

    a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 && mem_done) |=> (pc == $past(pc) + 1'b1) && (phase == 3'd1));

    a_r5_skip_mem: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1 && !hint_mem_op) |=> (phase == 3'd4));

    a_r5_addr_then_opnd: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2) |=> (phase == 3'd3));

    a_r7_exec_store: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4) |=> (phase == 3'd5));

    a_r9_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> ($countones(reg_wr_sel) == 1));

    a_r9_sel_idle: assert property (@(posedge clk) disable iff (rst)
        !reg_wr_en |-> (reg_wr_sel == '0));

    a_r12_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd0) |=> $stable(pc));
endmodule

bind icseq_top icseq_checker #(.ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR)) u_chk (
    .clk(clk), .rst(rst), .mem_done(mem_done), .hint_mem_op(hint_mem_op),
    .phase(phase), .pc(pc), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .decode_en(decode_en), .addr_en(addr_en), .alu_en(alu_en),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel)
);

// File: tb/icseq_top_tb_top.sv
module icseq_top_tb_top;
    localparam int AW = 4;
    localparam int WW = 16;
    localparam int NG = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_done = 1'b0;
    logic [WW-1:0] mem_rdata = '0;
    logic          hint_mem_op = 1'b0;
    logic          hint_mem_dst = 1'b0;
    logic [2:0]    hint_dst = '0;
    logic [2:0]    phase;
    logic [AW-1:0] pc;
    logic [WW-1:0] ir;
    logic          mem_rd_en, mem_wr_en, decode_en, addr_en, alu_en, reg_wr_en;
    logic [NG-1:0] reg_wr_sel;

    int checks = 0;
    int failures = 0;
    logic [AW-1:0] pc_model = '0;

    always #5 clk = ~clk;

    icseq_top #(.ADDR_W(AW), .WORD_W(WW), .NUM_GPR(NG)) dut_i (
        .clk(clk), .rst(rst), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .hint_mem_op(hint_mem_op), .hint_mem_dst(hint_mem_dst), .hint_dst(hint_dst),
        .phase(phase), .pc(pc), .ir(ir), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .decode_en(decode_en), .addr_en(addr_en), .alu_en(alu_en),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_enables();
        logic [5:0] v;
        v = {mem_rd_en, mem_wr_en, decode_en, addr_en, alu_en, reg_wr_en};
        chk($countones(v) == 1, "R11 one enable", 32'(v), 32'h1);
    endtask

    task automatic chk_phase(input logic [2:0] exp, input string req);
        chk(phase == exp, req, 32'(phase), 32'(exp));
        chk_enables();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        mem_done = 1'b0;
        step();
        step();
        rst = 1'b0;
        pc_model = '0;
        chk_phase(3'd0, "R1 reset phase");
        chk(pc == '0, "R1 reset pc", 32'(pc), 32'h0);
        chk(mem_rd_en == 1'b1, "R2 fetch read", 32'(mem_rd_en), 32'h1);
    endtask

    task automatic run_instr(input logic [WW-1:0] word, input bit mop, input bit mdst,
                             input logic [2:0] dst, input int fw, input int ow,
                             input int sw, input bit stray);
        logic [AW-1:0] exp_pc;
        exp_pc = pc_model + 1'b1;
        hint_mem_op  = !mop;
        hint_mem_dst = !mdst;
        hint_dst     = ~dst;
        mem_done     = 1'b0;
        for (int i = 0; i < fw; i++) begin
            chk_phase(3'd0, "R2 fetch wait");
            chk(mem_rd_en, "R2 read during wait", 32'(mem_rd_en), 32'h1);
            chk(pc == pc_model, "R3 pc held in wait", 32'(pc), 32'(pc_model));
            step();
        end
        chk_phase(3'd0, "R2 fetch");
        mem_done  = 1'b1;
        mem_rdata = word;
        step();
        mem_done  = stray;
        chk_phase(3'd1, "R4 decode after fetch");
        chk(decode_en, "R4 decode enable", 32'(decode_en), 32'h1);
        chk(ir == word, "R3 ir load", 32'(ir), 32'(word));
        chk(pc == exp_pc, "R3 pc advance", 32'(pc), 32'(exp_pc));
        hint_mem_op  = mop;
        hint_mem_dst = mdst;
        hint_dst     = dst;
        step();
        hint_mem_op  = !mop;
        hint_mem_dst = !mdst;
        hint_dst     = ~dst;
        if (mop) begin
            chk_phase(3'd2, "R5 address phase");
            chk(addr_en, "R5 addr enable", 32'(addr_en), 32'h1);
            step();
            mem_done = 1'b0;
            chk_phase(3'd3, "R6 operand phase");
            chk(mem_rd_en, "R6 operand read", 32'(mem_rd_en), 32'h1);
            for (int i = 0; i < ow; i++) begin
                step();
                chk_phase(3'd3, "R6 operand wait");
            end
            mem_done = 1'b1;
            step();
            mem_done = stray;
        end
        chk_phase(3'd4, mop ? "R6 execute after operand" : "R5 decode skips to execute");
        chk(alu_en, "R7 alu enable", 32'(alu_en), 32'h1);
        chk(pc == exp_pc, "R12 pc unaffected by stray done", 32'(pc), 32'(exp_pc));
        step();
        chk_phase(3'd5, "R7 store after execute");
        if (mdst) begin
            mem_done = 1'b0;
            chk(mem_wr_en && reg_wr_sel == '0, "R8 memory store", 32'(mem_wr_en), 32'h1);
            for (int i = 0; i < sw; i++) begin
                step();
                chk_phase(3'd5, "R8 store wait");
                chk(mem_wr_en, "R8 write held", 32'(mem_wr_en), 32'h1);
            end
            mem_done = 1'b1;
            step();
            mem_done = 1'b0;
        end else begin
            chk(reg_wr_en, "R9 register store", 32'(reg_wr_en), 32'h1);
            chk(reg_wr_sel == (NG'(1) << dst), "R10 R9 captured destination",
                32'(reg_wr_sel), 32'(NG'(1) << dst));
            mem_done = 1'b0;
            step();
        end
        chk_phase(3'd0, mdst ? "R8 back to fetch" : "R9 back to fetch");
        chk(pc == exp_pc, "R3 pc stable until next fetch", 32'(pc), 32'(exp_pc));
        pc_model = exp_pc;
    endtask

    task automatic t_reg_only();
        run_instr(16'h1234, 1'b0, 1'b0, 3'd5, 0, 0, 0, 1'b0);
    endtask

    task automatic t_mem_op_reg_store();
        run_instr(16'hA5C3, 1'b1, 1'b0, 3'd0, 3, 2, 0, 1'b0);
    endtask

    task automatic t_mem_op_mem_store();
        run_instr(16'h0F0F, 1'b1, 1'b1, 3'd2, 1, 0, 3, 1'b0);
    endtask

    task automatic t_reg_op_mem_store();
        run_instr(16'h7777, 1'b0, 1'b1, 3'd7, 2, 0, 1, 1'b0);
    endtask

    task automatic t_stray_done();
        run_instr(16'hBEEF, 1'b0, 1'b0, 3'd3, 0, 0, 0, 1'b1);
        run_instr(16'hCAFE, 1'b1, 1'b0, 3'd6, 0, 1, 0, 1'b1);
    endtask

    task automatic t_pc_wrap();
        for (int k = 0; k < 20; k++)
            run_instr(WW'(k * 3 + 1), k[0], k[1], 3'(k), 0, 0, 0, 1'b0);
    endtask

    task automatic t_mid_reset();
        mem_done = 1'b1;
        mem_rdata = 16'h4242;
        step();
        mem_done = 1'b0;
        hint_mem_op = 1'b0;
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        pc_model = '0;
        chk_phase(3'd0, "R1 reset mid instruction");
        chk(pc == '0, "R1 pc cleared mid instruction", 32'(pc), 32'h0);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_reg_only();
        t_mem_op_reg_store();
        t_mem_op_mem_store();
        t_reg_op_mem_store();
        t_stray_done();
        t_pc_wrap();
        t_mid_reset();
        run_instr(16'h5A5A, 1'b1, 1'b0, 3'd4, 0, 0, 0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule